// File: doc/BRIEF.md
# Clock Output Configuration Register

This block holds and applies the configuration of a multi-output clock generator. A byte-wide write port, fed by a serial host interface, loads a control byte and a set of output-enable bytes. A combinational read port returns the stored bytes. The control byte picks where the 4-bit frequency code comes from: either strap pins captured once when reset is released, or a field inside the control byte. The same byte drives the spread-spectrum enable, the spread mode (center or down) and a global tristate request.

Each raw clock produced by the synthesizer passes through its own gate. A cleared enable bit holds that output low. Enable changes are taken only on the falling edge of the raw clock they affect, so a high pulse is never cut short. One byte address is reserved. Writes to it are dropped in hardware, because loading it could put the generator into an undefined state.

Output indices (default 16 outputs): 0 REF0, 1 REF1, 2 IOAPIC1, 3 IOAPIC0, 4 CPU/2, 5 CPU2, 6 CPU1, 7 CPU0, 8 free-running PCI, 9 to 15 PCI1 to PCI7.

Top module: `clk_cfg_top`

## Requirements
- R1: After reset the control byte (address 0) reads 0x00, every enable byte reads 0xFF, all gated outputs follow their raw clocks, and freq_code_o equals the strap value.
- R2: Control bit 3 selects the frequency source. When it is 0, freq_code_o is the latched strap code. When it is 1, freq_code_o is {bit2, bit6, bit5, bit4} of the control byte, with bit2 as the MSB.
- R3: Control bit 7 drives spread_down_o (1 = down spread, 0 = center spread). Bit 1 drives spread_en_o and bit 0 drives tristate_o. Each reflects a write from the cycle after the write edge.
- R4: The strap pins are captured on the first clk_i edge after rst_ni is released. Later changes on the pins do not change freq_code_o.
- R5: A write to the reserved address (N_OUT/8 + 1, which is 3 by default) or to any higher address changes no stored state. Reads of those addresses return 0x00.
- R6: Enable byte k (address 1+k) bit i controls gated output 8k+i. A value of 1 lets the output run and a value of 0 holds it low.
- R7: An enable change reaches a gated output only at a falling edge of that output's raw clock. Clearing an enable while the raw clock is high leaves the current high pulse intact.
- R8: Reads of addresses 0 up to N_OUT/8 return the last value written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_i | input | 4 | Frequency strap pins |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 3 | Write byte address |
| wr_data_i | input | 8 | Write byte value |
| rd_addr_i | input | 3 | Read byte address |
| rd_data_o | output | 8 | Read byte value |
| clk_raw_i | input | 16 | Raw clocks from the synthesizer |
| clk_o | output | 16 | Gated clocks |
| freq_code_o | output | 4 | Selected frequency code |
| spread_en_o | output | 1 | Spread-spectrum enable |
| spread_down_o | output | 1 | Spread mode: 1 down, 0 center |
| tristate_o | output | 1 | Global output tristate request |

## Verification
Two functions can meet in the same moment: an enable bit is cleared by a register write while the raw clock it gates is in its high phase. The bench starts the write just after a raw rising edge, so the register update lands mid-pulse. It then checks that the output is still high before the raw falling edge and low on the raw high phase that follows. A second overlap comes from changing the strap pins after reset while the source bit flips back to strap. That case is judged by requiring the originally latched code to come back.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;
  localparam int CTRL_ADDR  = 0;
  localparam int EN_BASE    = 1;
  // control byte bit positions
  localparam int B_TRI      = 0;
  localparam int B_SPR_EN   = 1;
  localparam int B_FSRC     = 3;
  localparam int B_SPR_DOWN = 7;
endpackage

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import clk_cfg_pkg::*;
#(
  parameter int N_OUT = 16,
  parameter int AW    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [7:0]       rd_data_o,
  output logic [7:0]       ctrl_o,
  output logic [N_OUT-1:0] en_o
);
  localparam int N_EN = N_OUT / 8;
  localparam int RSV  = EN_BASE + N_EN;

  logic [7:0]       ctrl_q;
  logic [N_OUT-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_en_i && wr_addr_i == AW'(CTRL_ADDR)) ctrl_q <= wr_data_i;
  end

  for (genvar b = 0; b < N_EN; b++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q[b*8 +: 8] <= '1;
      else if (wr_en_i && wr_addr_i == AW'(EN_BASE + b)) en_q[b*8 +: 8] <= wr_data_i;
    end

    a_r6_en_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == AW'(EN_BASE + b)) |=> en_q[b*8 +: 8] == $past(wr_data_i));
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == AW'(CTRL_ADDR)) rd_data_o = ctrl_q;
    for (int b = 0; b < N_EN; b++)
      if (rd_addr_i == AW'(EN_BASE + b)) rd_data_o = en_q[b*8 +: 8];
  end

  assign ctrl_o = ctrl_q;
  assign en_o   = en_q;

  a_r3_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == AW'(CTRL_ADDR)) |=> ctrl_q == $past(wr_data_i));

  a_r5_rsv_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i >= AW'(RSV)) |=> ($stable(ctrl_q) && $stable(en_q)));
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] code_o
);
  logic         done_q;
  logic [W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      code_q <= '0;
    end else if (!done_q) begin
      done_q <= 1'b1;
      code_q <= pins_i;
    end
  end

  // before the first post-reset edge, pass the pins through
  assign code_o = done_q ? code_q : pins_i;

  a_r4_strap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> $stable(code_q));
endmodule

// File: rtl/clk_gate_low.sv
module clk_gate_low (
  input  logic clk_raw_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o
);
  logic en_q;

  // enable taken at falling edge: output only changes while clock is low
  always_ff @(negedge clk_raw_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b1;
    else         en_q <= en_i;
  end

  assign clk_o = clk_raw_i & en_q;
endmodule

// File: rtl/clk_cfg_top.sv
module clk_cfg_top
  import clk_cfg_pkg::*;
#(
  parameter int N_OUT = 16,
  parameter int AW    = 3,
  parameter int FW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [FW-1:0]    strap_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [7:0]       rd_data_o,
  input  logic [N_OUT-1:0] clk_raw_i,
  output logic [N_OUT-1:0] clk_o,
  output logic [FW-1:0]    freq_code_o,
  output logic             spread_en_o,
  output logic             spread_down_o,
  output logic             tristate_o
);
  logic [7:0]       ctrl;
  logic [N_OUT-1:0] en;
  logic [FW-1:0]    strap_code;
  logic [3:0]       reg_code;

  cfg_regfile #(.N_OUT(N_OUT), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_o, .ctrl_o(ctrl), .en_o(en)
  );

  strap_latch #(.W(FW)) u_strap (
    .clk_i, .rst_ni, .pins_i(strap_i), .code_o(strap_code)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_gate
    clk_gate_low u_gate (
      .clk_raw_i(clk_raw_i[i]), .rst_ni, .en_i(en[i]), .clk_o(clk_o[i])
    );
  end

  // register field order: bit2 is MSB, then bits 6..4
  assign reg_code      = {ctrl[2], ctrl[6], ctrl[5], ctrl[4]};
  assign freq_code_o   = ctrl[B_FSRC] ? FW'(reg_code) : strap_code;
  assign spread_en_o   = ctrl[B_SPR_EN];
  assign spread_down_o = ctrl[B_SPR_DOWN];
  assign tristate_o    = ctrl[B_TRI];
endmodule

// File: tb/clk_cfg_top_tb.sv
module clk_cfg_top_tb;
  localparam int N = 16;

  logic clk_i = 0, rst_ni = 0, raw = 0;
  logic [3:0] strap_i = 4'b1010;
  logic wr_en_i = 0;
  logic [2:0] wr_addr_i = 0, rd_addr_i = 0;
  logic [7:0] wr_data_i = 0, rd_data_o;
  logic [N-1:0] clk_o;
  logic [3:0] freq_code_o;
  logic spread_en_o, spread_down_o, tristate_o;
  logic rd_req = 0;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk_i = ~clk_i;
  initial begin #1; forever #20 raw = ~raw; end

  clk_cfg_top u_dut (
    .clk_i, .rst_ni, .strap_i, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_o, .clk_raw_i({N{raw}}), .clk_o,
    .freq_code_o, .spread_en_o, .spread_down_o, .tristate_o
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 0;
  endtask

  task automatic rd_expect(string req, logic [2:0] a, logic [7:0] e);
    @(negedge clk_i); rd_addr_i = a; rd_req = 1;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk_i); rd_req = 0;
  endtask

  // monitor: pops expected readback when a read is presented
  initial forever begin
    @(posedge clk_i); #2;
    if (rd_req && exp_q.size() > 0) chk(tag_q.pop_front(), {8'h0, rd_data_o}, {8'h0, exp_q.pop_front()});
  end

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    @(posedge raw); #3;
    chk("R1 outputs follow raw in reset", clk_o, 16'hFFFF);
    @(negedge clk_i); rst_ni = 1;
    repeat (2) @(negedge clk_i);
    strap_i = 4'b0101;
    repeat (2) @(negedge clk_i);
    chk("R1 R4 strap code latched", freq_code_o, 16'hA);
    chk("R1 spread/tristate clear", {spread_en_o, spread_down_o, tristate_o}, 0);
    rd_expect("R1 ctrl default", 0, 8'h00);
    rd_expect("R1 enable byte A default", 1, 8'hFF);
    rd_expect("R1 enable byte B default", 2, 8'hFF);

    // R2 R3: register code 0110 -> bit2=0 bit6=1 bit5=1 bit4=0, bit3 src, bit7 down, bit1 spread
    wr(0, 8'hEA);
    chk("R2 register code", freq_code_o, 16'h6);
    chk("R3 down/spread/tri", {spread_down_o, spread_en_o, tristate_o}, 3'b110);
    wr(0, 8'h3D); // bit3=1, bits 2,6,5,4 = 1,0,1,1 -> 1011, bit0 tristate
    chk("R2 register code msb from bit2", freq_code_o, 16'hB);
    chk("R3 tristate only", {spread_down_o, spread_en_o, tristate_o}, 3'b001);
    wr(0, 8'h01);
    chk("R2 R4 back to strap after pin change", freq_code_o, 16'hA);

    // R5 reserved and out of range
    wr(3, 8'h55);
    wr(5, 8'hAA);
    rd_expect("R5 reserved reads zero", 3, 8'h00);
    rd_expect("R5 high address reads zero", 5, 8'h00);
    rd_expect("R5 ctrl untouched", 0, 8'h01);
    rd_expect("R5 enable A untouched", 1, 8'hFF);
    chk("R5 tristate kept", tristate_o, 1);

    // R6 R8 enables
    wr(1, 8'hFE);
    wr(2, 8'h7F);
    rd_expect("R8 enable A readback", 1, 8'hFE);
    rd_expect("R8 enable B readback", 2, 8'h7F);
    @(posedge raw); @(posedge raw); #3;
    chk("R6 out0 and out15 held low", clk_o, 16'h7FFE);
    @(negedge raw); #3;
    chk("R6 all low in low phase", clk_o, 16'h0000);
    wr(1, 8'hFF); wr(2, 8'hFF);
    @(posedge raw); @(posedge raw); #3;
    chk("R6 re-enabled", clk_o, 16'hFFFF);

    // R7 disable inside high phase
    @(posedge raw);
    wr(1, 8'hFD);
    chk("R7 pulse not cut short", clk_o[1], 1);
    @(negedge raw); @(posedge raw); #3;
    chk("R7 disabled after falling edge", clk_o, 16'hFFFD);

    repeat (4) @(negedge clk_i);
    if (exp_q.size() != 0) chk("scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule